// File: doc/BRIEF.md
# Staged Pipeline Control Word Shifter

This block decodes an instruction's control signals once, in the register/decode stage, and then carries them down a five-stage pipeline beside the data. Three control registers sit at the decode/execute, execute/memory and memory/writeback boundaries. At each boundary the fields already used are dropped and only the fields later stages still need move on. Execute-stage fields are presented one cycle after an instruction is accepted, memory-stage fields two cycles after, and writeback fields three cycles after. The destination register number and a valid flag travel with the memory and writeback groups.

Decode offers an instruction on a valid/ready pair. `dec_ready` follows `!stall` and nothing else. While `stall` is high, decode must hold its opcode, function and register fields steady and keep `dec_valid` asserted. The decode/execute register loads the no-op word and the two downstream registers keep advancing, so the stall splits the pipe: the stages above it freeze and a bubble opens below it. `bubble` takes the offered instruction and discards it by loading the no-op word. The no-op word has every control bit at zero, including both write strobes, and destination zero. The datapath that uses these signals lies outside the block.

Top module: `pcs_ctrl_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all three stage registers to the no-op word, so every valid flag, strobe and destination reads zero after that edge. This applies even when the pipe holds instructions.
- R2: The opcode table is as follows. Each entry gives opcode: ext_op, alu_src, alu_op, reg_dst, mem_wr, branch, mem_to_reg, reg_wr.
  - Load 0x23: 1,1,00,0,0,0,1,1.
  - Store 0x2B: 1,1,00,0,1,0,0,0.
  - Branch-equal 0x04: 1,0,01,0,0,1,0,0.
  - Add-immediate 0x08: 1,1,00,0,0,0,0,1.
  - Or-immediate 0x0D: 0,1,11,0,0,0,0,1.
- R3: Opcode 0x00 is the register-register group, valid only for function codes 0x20, 0x22, 0x24, 0x25 and 0x2A. Its word is 0,0,10,1,0,0,0,1. Any other function code, or any opcode not listed, yields the no-op word with its valid flag low.
- R4: The execute group (valid, ext_op, alu_src, alu_op, reg_dst) of an instruction accepted at rising edge N is presented from edge N until edge N+1.
- R5: The memory group (valid, mem_wr, branch) and the destination of that instruction are presented after edge N+1.
- R6: The writeback group (valid, mem_to_reg, reg_wr) and the destination of that instruction are presented after edge N+2.
- R7: The destination is the rd field when reg_dst is 1 and the rt field otherwise.
- R8: While `stall` is high, `dec_ready` is low and the decode/execute register loads the no-op word. In the same cycles the execute/memory and memory/writeback registers still advance.
- R9: `bubble` with `stall` low accepts the offered instruction and squashes it to the no-op word.
- R10: With `dec_valid` low, the decode/execute register loads the no-op word.
- R11: When `stall` and `bubble` are high together, the stall rule governs: `dec_ready` is low and the held instruction is not lost. It is accepted once both inputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | Instruction taken this cycle (equals `!stall`) |
| dec_opcode | input | OPC_W | Opcode field |
| dec_funct | input | FN_W | Function field |
| dec_rt | input | RA_W | rt register number |
| dec_rd | input | RA_W | rd register number |
| stall | input | 1 | Freeze decode, insert no-op below |
| bubble | input | 1 | Squash the offered instruction |
| ex_valid | output | 1 | Execute group valid |
| ex_ext_op | output | 1 | Sign-extend immediate |
| ex_alu_src | output | 1 | ALU second operand is the immediate |
| ex_alu_op | output | 2 | ALU operation class |
| ex_reg_dst | output | 1 | Destination is rd |
| mem_valid | output | 1 | Memory group valid |
| mem_wr | output | 1 | Data memory write |
| mem_branch | output | 1 | Branch instruction |
| mem_dest | output | RA_W | Destination carried at memory |
| wb_valid | output | 1 | Writeback group valid |
| wb_mem_to_reg | output | 1 | Write back loaded data |
| wb_reg_wr | output | 1 | Register file write |
| wb_dest | output | RA_W | Destination carried at writeback |

## Verification
The most error-prone cycle is one where a stall, or a stall together with a bubble, lands while older instructions sit in the execute and memory registers. The block must insert a no-op at decode/execute and, in the same edge, shift the older words one stage further. The bench provokes this by streaming a load and a store back to back and raising stall, and then stall with bubble, on the cycle after them. A cycle-level model in the bench tracks the three stages from the requirement table. That model judges every stage output after each edge, and it also confirms that the held instruction appears exactly once after release.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // opcode encodings (R2, R3)
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ORI   = 6'h0D;

  // accepted register-register function codes (R3)
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10,
    ALU_OR   = 2'b11
  } alu_class_e;

  typedef struct packed {
    logic       ext_op;
    logic       alu_src;
    alu_class_e alu_op;
    logic       reg_dst;
  } ex_grp_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_grp_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_grp_t;

  typedef struct packed {
    logic     ok;
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctl_word_t;

  localparam ctl_word_t NOP_WORD = '0;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctl_word_t        word
);

  logic fn_known;

  always_comb begin
    fn_known = (funct == FN_W'(FN_ADD)) || (funct == FN_W'(FN_SUB)) ||
               (funct == FN_W'(FN_AND)) || (funct == FN_W'(FN_OR))  ||
               (funct == FN_W'(FN_SLT));
  end

  always_comb begin
    word = NOP_WORD;
    if (opcode == OPC_W'(OPC_REG)) begin
      if (fn_known) begin
        word.ok        = 1'b1;
        word.ex.alu_op = ALU_FUNC;
        word.ex.reg_dst = 1'b1;
        word.wb.reg_wr = 1'b1;
      end
    end else if (opcode == OPC_W'(OPC_LOAD)) begin
      word.ok            = 1'b1;
      word.ex.ext_op     = 1'b1;
      word.ex.alu_src    = 1'b1;
      word.ex.alu_op     = ALU_ADD;
      word.wb.mem_to_reg = 1'b1;
      word.wb.reg_wr     = 1'b1;
    end else if (opcode == OPC_W'(OPC_STORE)) begin
      word.ok         = 1'b1;
      word.ex.ext_op  = 1'b1;
      word.ex.alu_src = 1'b1;
      word.ex.alu_op  = ALU_ADD;
      word.mem.mem_wr = 1'b1;
    end else if (opcode == OPC_W'(OPC_BEQ)) begin
      word.ok         = 1'b1;
      word.ex.ext_op  = 1'b1;
      word.ex.alu_op  = ALU_SUB;
      word.mem.branch = 1'b1;
    end else if (opcode == OPC_W'(OPC_ADDI)) begin
      word.ok         = 1'b1;
      word.ex.ext_op  = 1'b1;
      word.ex.alu_src = 1'b1;
      word.ex.alu_op  = ALU_ADD;
      word.wb.reg_wr  = 1'b1;
    end else if (opcode == OPC_W'(OPC_ORI)) begin
      word.ok         = 1'b1;
      word.ex.alu_src = 1'b1;
      word.ex.alu_op  = ALU_OR;
      word.wb.reg_wr  = 1'b1;
    end
  end

  // R3: an invalid word carries no strobe
  always_comb begin
    if (!word.ok) begin
      assert (word.mem.mem_wr == 1'b0 && word.wb.reg_wr == 1'b0)
        else $error("p_nop_strobes_r3");
    end
  end

endmodule

// File: rtl/pcs_de_reg.sv
module pcs_de_reg
  import pcs_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            squash,
  input  ctl_word_t       word_i,
  input  logic [RA_W-1:0] rt_i,
  input  logic [RA_W-1:0] rd_i,
  output ctl_word_t       word_q,
  output logic [RA_W-1:0] rt_q,
  output logic [RA_W-1:0] rd_q
);

  logic load_real;
  assign load_real = take && !squash && word_i.ok;

  always_ff @(posedge clk) begin
    if (rst || !load_real) begin
      word_q <= NOP_WORD;
      rt_q   <= '0;
      rd_q   <= '0;
    end else begin
      word_q <= word_i;
      rt_q   <= rt_i;
      rd_q   <= rd_i;
    end
  end

  // R9: a squashed slot leaves no valid word at execute
  p_squash_nop_r9: assert property (@(posedge clk) disable iff (rst)
    squash |=> !word_q.ok);
  // R10: nothing offered means a no-op at execute
  p_idle_nop_r10: assert property (@(posedge clk) disable iff (rst)
    !take |=> (word_q == NOP_WORD));

endmodule

// File: rtl/pcs_em_reg.sv
module pcs_em_reg
  import pcs_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic            reg_dst_i,
  input  mem_grp_t        mem_i,
  input  wb_grp_t         wb_i,
  input  logic [RA_W-1:0] rt_i,
  input  logic [RA_W-1:0] rd_i,
  output logic            valid_q,
  output mem_grp_t        mem_q,
  output wb_grp_t         wb_q,
  output logic [RA_W-1:0] dest_q
);

  logic [RA_W-1:0] dest_sel;
  assign dest_sel = reg_dst_i ? rd_i : rt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mem_q   <= '0;
      wb_q    <= '0;
      dest_q  <= '0;
    end else begin
      valid_q <= valid_i;
      mem_q   <= mem_i;
      wb_q    <= wb_i;
      dest_q  <= dest_sel;
    end
  end

  // R5: memory stage follows execute one edge later
  p_follow_on_r5: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_q);
  p_follow_off_r5: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_q);
  // R2: store, branch and register write never share one word
  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_q.mem_wr, mem_q.branch, wb_q.reg_wr}));
  // R7: destination taken from rd for register-register words
  p_dest_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && reg_dst_i) |=> (dest_q == $past(rd_i)));

endmodule

// File: rtl/pcs_mw_reg.sv
module pcs_mw_reg
  import pcs_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  wb_grp_t         wb_i,
  input  logic [RA_W-1:0] dest_i,
  output logic            valid_q,
  output wb_grp_t         wb_q,
  output logic [RA_W-1:0] dest_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wb_q    <= '0;
      dest_q  <= '0;
    end else begin
      valid_q <= valid_i;
      wb_q    <= wb_i;
      dest_q  <= dest_i;
    end
  end

  // R6: writeback group and destination are the memory stage's, one edge on
  p_dest_carry_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (valid_q && dest_q == $past(dest_i) && wb_q == $past(wb_i)));
  p_write_valid_r6: assert property (@(posedge clk) disable iff (rst)
    wb_q.reg_wr |-> valid_q);

endmodule

// File: rtl/pcs_ctrl_shifter.sv
module pcs_ctrl_shifter
  import pcs_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FN_W  = 6,
  parameter int RA_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [OPC_W-1:0] dec_opcode,
  input  logic [FN_W-1:0] dec_funct,
  input  logic [RA_W-1:0] dec_rt,
  input  logic [RA_W-1:0] dec_rd,
  input  logic            stall,
  input  logic            bubble,
  output logic            ex_valid,
  output logic            ex_ext_op,
  output logic            ex_alu_src,
  output logic [1:0]      ex_alu_op,
  output logic            ex_reg_dst,
  output logic            mem_valid,
  output logic            mem_wr,
  output logic            mem_branch,
  output logic [RA_W-1:0] mem_dest,
  output logic            wb_valid,
  output logic            wb_mem_to_reg,
  output logic            wb_reg_wr,
  output logic [RA_W-1:0] wb_dest
);

  ctl_word_t       dec_word;
  ctl_word_t       de_word;
  logic [RA_W-1:0] de_rt, de_rd;
  logic            em_valid;
  mem_grp_t        em_mem;
  wb_grp_t         em_wb;
  logic [RA_W-1:0] em_dest;
  logic            mw_valid;
  wb_grp_t         mw_wb;
  logic [RA_W-1:0] mw_dest;
  logic            take;

  assign dec_ready = !stall;
  assign take      = dec_valid && dec_ready;

  pcs_decode #(.OPC_W(OPC_W), .FN_W(FN_W)) u_dec (
    .opcode (dec_opcode),
    .funct  (dec_funct),
    .word   (dec_word)
  );

  pcs_de_reg #(.RA_W(RA_W)) u_de (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .squash (bubble),
    .word_i (dec_word),
    .rt_i   (dec_rt),
    .rd_i   (dec_rd),
    .word_q (de_word),
    .rt_q   (de_rt),
    .rd_q   (de_rd)
  );

  pcs_em_reg #(.RA_W(RA_W)) u_em (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (de_word.ok),
    .reg_dst_i (de_word.ex.reg_dst),
    .mem_i     (de_word.mem),
    .wb_i      (de_word.wb),
    .rt_i      (de_rt),
    .rd_i      (de_rd),
    .valid_q   (em_valid),
    .mem_q     (em_mem),
    .wb_q      (em_wb),
    .dest_q    (em_dest)
  );

  pcs_mw_reg #(.RA_W(RA_W)) u_mw (
    .clk     (clk),
    .rst     (rst),
    .valid_i (em_valid),
    .wb_i    (em_wb),
    .dest_i  (em_dest),
    .valid_q (mw_valid),
    .wb_q    (mw_wb),
    .dest_q  (mw_dest)
  );

  assign ex_valid      = de_word.ok;
  assign ex_ext_op     = de_word.ex.ext_op;
  assign ex_alu_src    = de_word.ex.alu_src;
  assign ex_alu_op     = de_word.ex.alu_op;
  assign ex_reg_dst    = de_word.ex.reg_dst;
  assign mem_valid     = em_valid;
  assign mem_wr        = em_mem.mem_wr;
  assign mem_branch    = em_mem.branch;
  assign mem_dest      = em_dest;
  assign wb_valid      = mw_valid;
  assign wb_mem_to_reg = mw_wb.mem_to_reg;
  assign wb_reg_wr     = mw_wb.reg_wr;
  assign wb_dest       = mw_dest;

  // R1: reset empties every stage at the next edge
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!ex_valid && !mem_valid && !wb_valid && !mem_wr && !wb_reg_wr));
  // R8: stall puts a no-op at execute while execute still drains into memory
  p_stall_nop_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ex_valid);
  p_stall_drain_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && ex_valid) |=> mem_valid);
  // R11: a held offer with stall and bubble together is not consumed
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (stall && dec_valid) |-> !dec_ready);

endmodule

// File: tb/sim_pcs_ctrl_shifter.sv
`timescale 1ns/1ps
module sim_pcs_ctrl_shifter;

  localparam int RA = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic dec_ready;
  logic [5:0] dec_opcode = '0;
  logic [5:0] dec_funct = '0;
  logic [RA-1:0] dec_rt = '0;
  logic [RA-1:0] dec_rd = '0;
  logic stall = 1'b0;
  logic bubble = 1'b0;
  logic ex_valid, ex_ext_op, ex_alu_src, ex_reg_dst;
  logic [1:0] ex_alu_op;
  logic mem_valid, mem_wr, mem_branch;
  logic [RA-1:0] mem_dest;
  logic wb_valid, wb_mem_to_reg, wb_reg_wr;
  logic [RA-1:0] wb_dest;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: [9]valid [8]ext [7]src [6:5]aluop [4]regdst [3]memwr [2]branch [1]m2r [0]regwr
  logic [9:0]    m1 = '0, m2 = '0, m3 = '0;
  logic [RA-1:0] d1 = '0, d2 = '0, d3 = '0;

  always #5 clk = ~clk;

  pcs_ctrl_shifter u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_opcode(dec_opcode), .dec_funct(dec_funct), .dec_rt(dec_rt), .dec_rd(dec_rd),
    .stall(stall), .bubble(bubble),
    .ex_valid(ex_valid), .ex_ext_op(ex_ext_op), .ex_alu_src(ex_alu_src),
    .ex_alu_op(ex_alu_op), .ex_reg_dst(ex_reg_dst),
    .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_branch(mem_branch), .mem_dest(mem_dest),
    .wb_valid(wb_valid), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr), .wb_dest(wb_dest)
  );

  function automatic logic [9:0] exp_ctl(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: exp_ctl = (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)
                       ? 10'b1_0_0_10_1_0_0_0_1 : 10'b0;
      6'h23: exp_ctl = 10'b1_1_1_00_0_0_0_1_1;
      6'h2B: exp_ctl = 10'b1_1_1_00_0_1_0_0_0;
      6'h04: exp_ctl = 10'b1_1_0_01_0_0_1_0_0;
      6'h08: exp_ctl = 10'b1_1_1_00_0_0_0_0_1;
      6'h0D: exp_ctl = 10'b1_0_1_11_0_0_0_0_1;
      default: exp_ctl = 10'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_stages(input string tag);
    chk({tag, " R4 ex"}, 16'({ex_valid, ex_ext_op, ex_alu_src, ex_alu_op, ex_reg_dst}), 16'(m1[9:4]));
    chk({tag, " R5 R7 mem"}, 16'({mem_valid, mem_wr, mem_branch, mem_dest}), 16'({m2[9], m2[3], m2[2], d2}));
    chk({tag, " R6 R7 wb"}, 16'({wb_valid, wb_mem_to_reg, wb_reg_wr, wb_dest}), 16'({m3[9], m3[1], m3[0], d3}));
  endtask

  // one clock cycle: drive at negedge, judge after the rising edge
  task automatic cyc(input logic v, input logic [5:0] op, input logic [5:0] fn,
                     input logic [RA-1:0] rt, input logic [RA-1:0] rd,
                     input logic st, input logic bb, input string tag);
    logic [9:0] e;
    logic acc;
    @(negedge clk);
    dec_valid = v; dec_opcode = op; dec_funct = fn; dec_rt = rt; dec_rd = rd;
    stall = st; bubble = bb;
    #1;
    chk({tag, " R8 ready"}, 16'(dec_ready), 16'(!st));
    e   = exp_ctl(op, fn);
    acc = v && !st && !bb && e[9];
    @(posedge clk);
    #1;
    m3 = m2; d3 = d2;
    m2 = m1; d2 = d1;
    m1 = acc ? e : 10'b0;
    d1 = acc ? (e[4] ? rd : rt) : '0;
    check_stages(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 6'h00, 6'h00, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; dec_valid = 1'b0; stall = 1'b0; bubble = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset outputs", 16'({ex_valid, mem_valid, wb_valid, mem_wr, mem_branch, wb_reg_wr,
                                wb_mem_to_reg, mem_dest, wb_dest}), 16'h0);
    m1 = '0; m2 = '0; m3 = '0; d1 = '0; d2 = '0; d3 = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_table();
    cyc(1'b1, 6'h23, 6'h00, 5'd1, 5'd9, 1'b0, 1'b0, "R2 load");
    idle(3, "R2 load drain");
    cyc(1'b1, 6'h2B, 6'h00, 5'd3, 5'd4, 1'b0, 1'b0, "R2 store");
    idle(3, "R2 store drain");
    cyc(1'b1, 6'h04, 6'h00, 5'd7, 5'd6, 1'b0, 1'b0, "R2 beq");
    idle(3, "R2 beq drain");
    cyc(1'b1, 6'h08, 6'h00, 5'd2, 5'd30, 1'b0, 1'b0, "R2 addi");
    idle(3, "R2 addi drain");
    cyc(1'b1, 6'h0D, 6'h11, 5'd8, 5'd12, 1'b0, 1'b0, "R2 ori");
    idle(3, "R2 ori drain");
  endtask

  task automatic t_regreg();
    cyc(1'b1, 6'h00, 6'h20, 5'd4, 5'd3, 1'b0, 1'b0, "R3 R7 add rd");
    cyc(1'b1, 6'h00, 6'h22, 5'd5, 5'd10, 1'b0, 1'b0, "R3 sub");
    cyc(1'b1, 6'h00, 6'h2A, 5'd6, 5'd31, 1'b0, 1'b0, "R3 slt");
    cyc(1'b1, 6'h00, 6'h07, 5'd6, 5'd11, 1'b0, 1'b0, "R3 bad funct");
    cyc(1'b1, 6'h3F, 6'h20, 5'd6, 5'd11, 1'b0, 1'b0, "R3 bad opcode");
    idle(3, "R3 drain");
  endtask

  task automatic t_stream();
    cyc(1'b1, 6'h23, 6'h00, 5'd1, 5'd2, 1'b0, 1'b0, "R4 stream lw");
    cyc(1'b1, 6'h00, 6'h25, 5'd3, 5'd13, 1'b0, 1'b0, "R5 stream or");
    cyc(1'b1, 6'h2B, 6'h00, 5'd14, 5'd15, 1'b0, 1'b0, "R6 stream sw");
    cyc(1'b1, 6'h04, 6'h00, 5'd16, 5'd17, 1'b0, 1'b0, "R6 stream beq");
    idle(3, "R6 stream drain");
  endtask

  task automatic t_stall();
    cyc(1'b1, 6'h23, 6'h00, 5'd20, 5'd21, 1'b0, 1'b0, "R8 pre lw");
    cyc(1'b1, 6'h2B, 6'h00, 5'd22, 5'd23, 1'b0, 1'b0, "R8 pre sw");
    cyc(1'b1, 6'h08, 6'h00, 5'd24, 5'd25, 1'b1, 1'b0, "R8 stall 1");
    cyc(1'b1, 6'h08, 6'h00, 5'd24, 5'd25, 1'b1, 1'b0, "R8 stall 2");
    cyc(1'b1, 6'h08, 6'h00, 5'd24, 5'd25, 1'b0, 1'b0, "R8 release");
    idle(3, "R8 drain");
  endtask

  task automatic t_bubble();
    cyc(1'b1, 6'h00, 6'h24, 5'd1, 5'd5, 1'b0, 1'b0, "R9 pre and");
    cyc(1'b1, 6'h23, 6'h00, 5'd9, 5'd9, 1'b0, 1'b1, "R9 squash lw");
    cyc(1'b1, 6'h2B, 6'h00, 5'd9, 5'd9, 1'b0, 1'b1, "R9 squash sw");
    idle(3, "R9 drain");
  endtask

  task automatic t_idle();
    cyc(1'b0, 6'h23, 6'h00, 5'd4, 5'd4, 1'b0, 1'b0, "R10 valid low lw");
    cyc(1'b0, 6'h00, 6'h20, 5'd4, 5'd4, 1'b0, 1'b0, "R10 valid low add");
    idle(2, "R10 drain");
  endtask

  task automatic t_both();
    cyc(1'b1, 6'h23, 6'h00, 5'd11, 5'd12, 1'b0, 1'b0, "R11 pre lw");
    cyc(1'b1, 6'h2B, 6'h00, 5'd13, 5'd14, 1'b0, 1'b0, "R11 pre sw");
    cyc(1'b1, 6'h0D, 6'h00, 5'd18, 5'd19, 1'b1, 1'b1, "R11 stall+bubble");
    cyc(1'b1, 6'h0D, 6'h00, 5'd18, 5'd19, 1'b0, 1'b0, "R11 release");
    idle(3, "R11 drain");
  endtask

  task automatic t_reset_full();
    cyc(1'b1, 6'h23, 6'h00, 5'd1, 5'd2, 1'b0, 1'b0, "R1 fill a");
    cyc(1'b1, 6'h2B, 6'h00, 5'd3, 5'd4, 1'b0, 1'b0, "R1 fill b");
    cyc(1'b1, 6'h00, 6'h20, 5'd5, 5'd6, 1'b0, 1'b0, "R1 fill c");
    t_reset();
    idle(1, "R1 after reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_table();
    t_regreg();
    t_stream();
    t_stall();
    t_bubble();
    t_idle();
    t_both();
    t_reset_full();
    finish_run();
  end

endmodule